// File: doc/BRIEF.md
# MII Management Frame Engine

This block carries out one PHY register access at a time over a two-wire management interface made of a clock (MDC) and a bidirectional data line (MDIO). The host writes one 32-bit command word. That single write starts a complete management frame: a preamble of ones, followed by every bit of the command word, most significant bit first. For a write the whole word goes out on the line. For a read the engine drives only the leading control and address bits. It then releases the line for the turnaround and data bits, and shifts in the 16 bits the PHY returns.

When the frame ends, the engine sets a sticky completion bit in a 32-bit event register and drops its busy status. The host clears the completion bit by writing a one to it. After a read, the data register holds the command's upper half with the returned PHY value in the low 16 bits. MDC is produced from the system clock by a half-period divider, so its frequency is the system clock divided by twice the programmed speed value. The MDIO pad is modelled as three separate signals: data out, output enable and data in.

Top module: `mdio_mgmt_engine`

## Requirements
- R1: A command write (cmd_we high on a clock edge) is accepted when the engine is idle and speed is nonzero. busy is then high from the next cycle until the frame ends.
- R2: MDC is low while idle. During a frame it toggles every `speed` system clocks, giving exactly 64 rising MDC edges per frame. busy stays high for 128*speed clocks.
- R3: The frame on mdio_o, sampled at each rising MDC edge, is 32 ones followed by command bits 31 down to 0. The word layout is: start [31:30], opcode [29:28], PHY address [27:23], register address [22:18], turnaround [17:16], data [15:0].
- R4: Opcode 2'b10 is a read; any other opcode is a write. For a read, mdio_oe is low for the last 18 frame bits (turnaround and data). Otherwise mdio_oe is high for the whole frame.
- R5: For a read, mdio_i is sampled on the rising MDC edges of the last 16 frame bits, first bit as the MSB. At completion rd_data holds {command[31:16], returned value}.
- R6: At the end of every frame, bit 23 of event_o becomes 1 in the same cycle that busy falls. The bit stays 1 until it is cleared.
- R7: Writing evt_clr_wdata with bit 23 set (evt_clr_we high) clears event bit 23. Writing a zero leaves it unchanged. All other event bits always read 0.
- R8: With speed equal to 0, a command write is ignored: busy stays low, MDC stays low, rd_data and event_o are unchanged.
- R9: A command written while busy is ignored. The running frame, its completion data and its length are unaffected.
- R10: On accepting any command, rd_data takes the full command word. After a write frame it still holds that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| speed | input | DIV_W | MDC half period in system clocks; 0 disables |
| cmd_we | input | 1 | Command word write strobe |
| cmd_wdata | input | 32 | Command word |
| evt_clr_we | input | 1 | Event register write strobe (write-one-to-clear) |
| evt_clr_wdata | input | 32 | Event clear mask |
| rd_data | output | 32 | Data register: command word, low half replaced by read data |
| event_o | output | 32 | Event register, completion at bit 23 |
| busy | output | 1 | Frame in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO pad output value |
| mdio_oe | output | 1 | MDIO pad output enable |
| mdio_i | input | 1 | MDIO pad input value |

## Verification
The bench builds the engine with its default parameters: a 32-bit preamble, an 8-bit speed field and the completion event at bit 23. It runs frames at speed values 1, 2 and 3, and also tries speed 0. Speed 1 covers the tightest case, where the rising and falling MDC strobes fall on consecutive clocks and the last falling edge coincides with completion. The larger values show that the frame length scales as 128 times the speed. A behavioural PHY on the bench drives read values that have their MSB set, their LSB set and mixed bits, so that capture order and turnaround release can be checked bit by bit.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
    localparam int          CMD_W   = 32;
    localparam int          DATA_W  = 16;
    localparam int          OP_HI   = 29;
    localparam int          OP_LO   = 28;
    localparam logic [1:0]  OP_READ = 2'b10;
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] speed,
    output logic             mdc,
    output logic             rise_stb,
    output logic             fall_stb
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             mdc;
    } div_t;

    div_t q, d;
    logic tick;

    always_comb begin
        d    = q;
        tick = run && (q.cnt == (speed - DIV_W'(1)));
        if (!run) begin
            d.cnt = '0;
            d.mdc = 1'b0;
        end else if (tick) begin
            d.cnt = '0;
            d.mdc = ~q.mdc;
        end else begin
            d.cnt = q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mdc      = q.mdc;
    assign rise_stb = tick && !q.mdc;
    assign fall_stb = tick && q.mdc;

    // R2: clock parks low whenever no frame runs
    a_r2_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mdc);

    // R2: between divider terminal counts the clock level holds
    a_r2_hold_level: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !rise_stb && !fall_stb) |=> $stable(mdc));
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_mgmt_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [CMD_W-1:0]  cmd_in,
    input  logic              rise_stb,
    input  logic              fall_stb,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              busy,
    output logic              is_read,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);
    localparam int FRAME_LEN = PRE_LEN + CMD_W;
    localparam int IDX_W     = $clog2(FRAME_LEN);
    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(FRAME_LEN - 1);
    localparam logic [IDX_W-1:0] PRE_END   = IDX_W'(PRE_LEN);
    localparam logic [IDX_W-1:0] REL_START = IDX_W'(FRAME_LEN - DATA_W - 2);
    localparam logic [IDX_W-1:0] CAP_START = IDX_W'(FRAME_LEN - DATA_W);

    typedef struct packed {
        logic              busy;
        logic              rd;
        logic [IDX_W-1:0]  idx;
        logic [CMD_W-1:0]  sh;
        logic [DATA_W-1:0] cap;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d    = q;
        done = 1'b0;
        if (go) begin
            d.busy = 1'b1;
            d.rd   = (cmd_in[OP_HI:OP_LO] == OP_READ);
            d.idx  = '0;
            d.sh   = cmd_in;
            d.cap  = '0;
        end else if (q.busy) begin
            if (rise_stb && q.rd && (q.idx >= CAP_START))
                d.cap = {q.cap[DATA_W-2:0], mdio_i};
            if (fall_stb) begin
                if (q.idx == LAST_IDX) begin
                    d.busy = 1'b0;
                    done   = 1'b1;
                end else begin
                    d.idx = q.idx + IDX_W'(1);
                    if (q.idx >= PRE_END)
                        d.sh = {q.sh[CMD_W-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mdio_o  = (q.idx < PRE_END) ? 1'b1 : q.sh[CMD_W-1];
    assign mdio_oe = q.busy && !(q.rd && (q.idx >= REL_START));
    assign busy    = q.busy;
    assign is_read = q.rd;
    assign rdata   = q.cap;

    // R3: the preamble is always driven high
    a_r3_preamble_driven: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && (q.idx < PRE_END)) |-> (mdio_oe && mdio_o));

    // R4: the line is only ever released on a read
    a_r4_release_read_only: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && !mdio_oe) |-> q.rd);

    // R1: an accepted command starts a frame at bit zero
    a_r1_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> (busy && (q.idx == '0)));
endmodule

// File: rtl/mdio_mgmt_engine.sv
module mdio_mgmt_engine
    import mdio_mgmt_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int PRE_LEN = 32,
    parameter int EVT_BIT = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] speed,
    input  logic             cmd_we,
    input  logic [31:0]      cmd_wdata,
    input  logic             evt_clr_we,
    input  logic [31:0]      evt_clr_wdata,
    output logic [31:0]      rd_data,
    output logic [31:0]      event_o,
    output logic             busy,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_i
);
    typedef struct packed {
        logic [CMD_W-1:0] data;
        logic [31:0]      evt;
    } regs_t;

    regs_t q, d;

    logic              go, done, is_read, rise_stb, fall_stb;
    logic [DATA_W-1:0] rdata;

    assign go = cmd_we && !busy && (speed != '0);

    mdio_clkdiv #(.DIV_W(DIV_W)) i_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .speed    (speed),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_frame_seq #(.PRE_LEN(PRE_LEN)) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .cmd_in   (cmd_wdata),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .mdio_i   (mdio_i),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .busy     (busy),
        .is_read  (is_read),
        .done     (done),
        .rdata    (rdata)
    );

    always_comb begin
        d = q;
        if (go)
            d.data = cmd_wdata;
        else if (done && is_read)
            d.data[DATA_W-1:0] = rdata;
        if (evt_clr_we)
            d.evt = q.evt & ~evt_clr_wdata;
        if (done)
            d.evt[EVT_BIT] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_data = q.data;
    assign event_o = q.evt;

    // R6: completion is flagged when busy drops
    a_r6_event_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> event_o[EVT_BIT]);

    // R8: a zero divider never starts a frame
    a_r8_zero_speed_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (speed == '0)) |=> !busy);

    // R9: the data register holds while a frame is in flight
    a_r9_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable(rd_data));
endmodule

// File: tb/test_mdio_mgmt_engine.sv
module test_mdio_mgmt_engine;
    localparam int CLK_PERIOD = 10;
    localparam int EB = 23;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  speed = 8'd1;
    logic        cmd_we = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic        evt_clr_we = 1'b0;
    logic [31:0] evt_clr_wdata = '0;
    logic [31:0] rd_data, event_o;
    logic        busy, mdc, mdio_o, mdio_oe, mdio_i;

    logic [15:0] phy_val = '0;
    int          rcnt = 0;
    int          hi_cnt = 0;
    logic        prev_mdc = 1'b0, prev_busy = 1'b0;
    logic        log_o [64];
    logic        log_oe[64];

    logic [31:0] exp_cmd[$];
    logic [15:0] exp_phy[$];
    int          exp_spd[$];

    int total = 0, bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdio_mgmt_engine i_mdio_mgmt_engine (
        .clk(clk), .rst_n(rst_n), .speed(speed),
        .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .evt_clr_we(evt_clr_we), .evt_clr_wdata(evt_clr_wdata),
        .rd_data(rd_data), .event_o(event_o), .busy(busy),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // behavioural PHY: presents the read value for the next rising MDC edge
    assign mdio_i = (rcnt >= 48 && rcnt < 64) ? phy_val[63 - rcnt] : 1'b1;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [1:0] op, input logic [4:0] phy,
                                       input logic [4:0] rg, input logic [15:0] dat);
        return {2'b01, op, phy, rg, 2'b10, dat};
    endfunction

    // monitor: logs bits on rising MDC, compares against the scoreboard at frame end
    always @(negedge clk) begin
        if (busy) begin
            hi_cnt++;
            if (mdc && !prev_mdc) begin
                if (rcnt < 64) begin
                    log_o[rcnt]  = mdio_o;
                    log_oe[rcnt] = mdio_oe;
                end
                rcnt++;
            end
        end else if (prev_busy) begin
            if (exp_cmd.size() == 0) begin
                check(0, "R9 unexpected frame", 0, 0);
            end else begin
                logic [31:0] c;
                logic [15:0] pv;
                int          sp, bad_o, bad_oe;
                bit          rd;
                c  = exp_cmd.pop_front();
                pv = exp_phy.pop_front();
                sp = exp_spd.pop_front();
                rd = (c[29:28] == 2'b10);
                bad_o = 0; bad_oe = 0;
                for (int k = 0; k < 64; k++) begin
                    logic eoe, eo;
                    eoe = !(rd && k >= 46);
                    eo  = (k < 32) ? 1'b1 : c[63 - k];
                    if (log_oe[k] !== eoe) bad_oe++;
                    if (eoe && log_o[k] !== eo) bad_o++;
                end
                check(rcnt == 64, "R2 rising edge count", rcnt, 64);
                check(hi_cnt == 128 * sp, "R2 frame length", hi_cnt, 128 * sp);
                check(bad_o == 0, "R3 frame bits", bad_o, 0);
                check(bad_oe == 0, "R4 output enable", bad_oe, 0);
                if (rd)
                    check(rd_data === {c[31:16], pv}, "R5 read data", rd_data, {c[31:16], pv});
                else
                    check(rd_data === c, "R10 write data reg", rd_data, c);
                check(event_o[EB] === 1'b1, "R6 completion event", event_o, 32'h0080_0000);
            end
            rcnt   = 0;
            hi_cnt = 0;
        end
        prev_mdc  = mdc;
        prev_busy = busy;
    end

    task automatic issue(input logic [31:0] c, input logic [15:0] pv, input int sp);
        @(negedge clk);
        speed   = 8'(sp);
        phy_val = pv;
        exp_cmd.push_back(c);
        exp_phy.push_back(pv);
        exp_spd.push_back(sp);
        cmd_we    = 1'b1;
        cmd_wdata = c;
        @(negedge clk);
        cmd_we = 1'b0;
        check(busy === 1'b1, "R1 busy after accept", busy, 1);
        check(rd_data === c, "R10 data reg loaded", rd_data, c);
    endtask

    task automatic wait_done();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic clr_evt(input logic [31:0] m);
        @(negedge clk);
        evt_clr_we = 1'b1;
        evt_clr_wdata = m;
        @(negedge clk);
        evt_clr_we = 1'b0;
    endtask

    initial begin
        repeat (200000) @(negedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 1'b0, "R1 reset busy", busy, 0);
        check(mdc === 1'b0, "R2 reset mdc", mdc, 0);
        check(event_o === 32'h0, "R7 reset event", event_o, 0);
        check(mdio_oe === 1'b0, "R4 reset oe", mdio_oe, 0);

        // write frames at different divider values
        issue(mk(2'b01, 5'h01, 5'h00, 16'h8000), 16'h0, 1);
        wait_done();
        check(mdc === 1'b0, "R2 idle mdc after frame", mdc, 0);
        issue(mk(2'b01, 5'h15, 5'h0A, 16'hA5C3), 16'h0, 3);
        wait_done();

        // W1C behaviour of the completion bit
        clr_evt(32'h0);
        check(event_o[EB] === 1'b1, "R7 zero write keeps event", event_o, 32'h0080_0000);
        clr_evt(32'h0080_0000);
        check(event_o === 32'h0, "R7 one clears event", event_o, 0);

        // reads with MSB, LSB and mixed patterns
        issue(mk(2'b10, 5'h1F, 5'h01, 16'h0), 16'h796D, 2);
        wait_done();
        issue(mk(2'b10, 5'h00, 5'h1F, 16'hFFFF), 16'h0001, 1);
        wait_done();
        issue(mk(2'b10, 5'h0A, 5'h15, 16'h0), 16'h8000, 1);
        wait_done();
        check(event_o === 32'h0080_0000, "R7 other event bits zero", event_o, 32'h0080_0000);

        // zero divider ignores the command
        clr_evt(32'hFFFF_FFFF);
        held = rd_data;
        @(negedge clk);
        speed = 8'd0;
        cmd_we = 1'b1;
        cmd_wdata = mk(2'b01, 5'h03, 5'h04, 16'h1234);
        @(negedge clk);
        cmd_we = 1'b0;
        check(busy === 1'b0, "R8 no start at zero speed", busy, 0);
        repeat (40) @(negedge clk);
        check(mdc === 1'b0, "R8 mdc idle at zero speed", mdc, 0);
        check(rd_data === held, "R8 data unchanged", rd_data, held);
        check(event_o === 32'h0, "R8 no event", event_o, 0);

        // command during a frame is ignored
        issue(mk(2'b10, 5'h11, 5'h02, 16'h0), 16'hC3A5, 2);
        repeat (30) @(negedge clk);
        cmd_we = 1'b1;
        cmd_wdata = mk(2'b01, 5'h07, 5'h07, 16'h5555);
        @(negedge clk);
        cmd_we = 1'b0;
        check(busy === 1'b1, "R9 busy kept", busy, 1);
        wait_done();
        repeat (20) @(negedge clk);
        check(busy === 1'b0, "R9 no second frame", busy, 0);
        check(exp_cmd.size() == 0, "R9 scoreboard drained", exp_cmd.size(), 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule